// File: doc/BRIEF.md
# Power-State Request Handshake Controller

This block sits on the controller side of one power-state request channel. Local logic gives it a target power state and a one-cycle start command. The block puts the target on the state bus and waits a full cycle so the value is settled. It then raises the request line and waits for the managed device to answer with either an accept or a deny. After the answer it drops the request, waits for the device to drop its answer, and then reports the result as a one-cycle done pulse with a denied flag.

The block keeps the last state the device accepted. While reset is held, and for a set number of cycles after it, the state bus carries a fixed initial state, so the device can sample a valid value when its own reset is released. A sticky error flag records device responses that break the protocol.

Top module: `pch_ctrl`

## Requirements
- R1: While `rst` is high, `preq_o` is 0, `pstate_o` and `cur_state_o` equal `INIT_STATE`, `busy_o` is 1, and `done_o`, `denied_o` and `err_o` are 0.
- R2: For `RST_HOLD` cycles after `rst` falls, `busy_o` stays 1, `start_i` is ignored and `pstate_o` keeps `INIT_STATE`.
- R3: A start that is accepted in the idle state puts `target_i` on `pstate_o` one cycle later while `preq_o` stays 0. `preq_o` rises one cycle after that, and only while `paccept_i` and `pdeny_i` are both 0.
- R4: `preq_o` falls in the cycle after exactly one of `paccept_i` or `pdeny_i` is seen high. While both are high, `preq_o` stays high.
- R5: `pstate_o` changes only after a cycle in which `preq_o`, `paccept_i` and `pdeny_i` were all 0.
- R6: `done_o` is high for exactly one cycle, in the cycle after the device has dropped its answer. `denied_o` is 1 with it after a deny and 0 after an accept.
- R7: `cur_state_o` takes the requested state when the device accepts. A deny leaves it unchanged.
- R8: `start_i` has no effect while `busy_o` is 1. It also has no effect while `paccept_i` or `pdeny_i` is high.
- R9: `err_o` is set if `paccept_i` and `pdeny_i` are high together, or if either one rises while `preq_o` is 0. Once set, it stays set until reset.
- R10: `busy_o` is 1 from the cycle after an accepted start until the cycle in which `done_o` pulses. In that cycle `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a handshake toward `target_i` |
| target_i | input | STATE_W | Requested power state |
| busy_o | output | 1 | Handshake or post-reset hold in progress |
| done_o | output | 1 | One-cycle completion pulse |
| denied_o | output | 1 | With `done_o`: 1 if the device denied |
| cur_state_o | output | STATE_W | Last accepted power state |
| err_o | output | 1 | Sticky protocol-violation flag |
| preq_o | output | 1 | Request line to the device |
| pstate_o | output | STATE_W | Power state bus to the device |
| paccept_i | input | 1 | Device accept |
| pdeny_i | input | 1 | Device deny |

## Verification
The handshake is run to completion with an accept and separately with a deny, using different target values. This shows that only an accept moves the recorded state and that the denied flag follows the type of answer. A start command held through an active handshake, and a start during the post-reset hold, show whether the state bus is truly frozen. Two kinds of device misbehaviour, both answers raised at once and an answer raised with no request pending, show whether the error flag sets, and whether the request line waits for a single clean answer before it drops.

// File: rtl/pch_pkg.sv
package pch_pkg;

    typedef enum logic [2:0] {
        HS_HOLD    = 3'd0,
        HS_IDLE    = 3'd1,
        HS_SETUP   = 3'd2,
        HS_REQ     = 3'd3,
        HS_RELEASE = 3'd4
    } hs_state_e;

    typedef enum logic {
        RES_ACCEPT = 1'b0,
        RES_DENY   = 1'b1
    } hs_result_e;

    typedef struct packed {
        logic       load;
        logic       commit;
        logic       finish;
        hs_result_e result;
    } hs_ctrl_t;

    function automatic logic resp_quiet(input logic acc, input logic dny);
        return !acc && !dny;
    endfunction

    function automatic logic resp_single(input logic acc, input logic dny);
        return acc ^ dny;
    endfunction

endpackage

// File: rtl/pch_fsm.sv
module pch_fsm
    import pch_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     paccept_i,
    input  logic     pdeny_i,
    output logic     preq_o,
    output logic     busy_o,
    output hs_ctrl_t ctrl_o
);

    localparam int CW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);

    hs_state_e  st_q, st_d;
    logic [CW-1:0] cnt_q;
    hs_result_e res_q, res_d;
    logic quiet;

    assign quiet = resp_quiet(paccept_i, pdeny_i);

    always_comb begin
        st_d          = st_q;
        res_d         = res_q;
        ctrl_o.load   = 1'b0;
        ctrl_o.commit = 1'b0;
        ctrl_o.finish = 1'b0;
        case (st_q)
            HS_HOLD: begin
                if (cnt_q == HOLD_LAST) st_d = HS_IDLE;
            end
            HS_IDLE: begin
                if (start_i && quiet) begin
                    st_d        = HS_SETUP;
                    ctrl_o.load = 1'b1;
                end
            end
            HS_SETUP: begin
                if (quiet) st_d = HS_REQ;
            end
            HS_REQ: begin
                if (resp_single(paccept_i, pdeny_i)) begin
                    st_d = HS_RELEASE;
                    if (paccept_i) begin
                        res_d         = RES_ACCEPT;
                        ctrl_o.commit = 1'b1;
                    end else begin
                        res_d = RES_DENY;
                    end
                end
            end
            HS_RELEASE: begin
                if (quiet) begin
                    st_d          = HS_IDLE;
                    ctrl_o.finish = 1'b1;
                end
            end
            default: st_d = HS_HOLD;
        endcase
        ctrl_o.result = res_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_HOLD;
            cnt_q <= '0;
            res_q <= RES_ACCEPT;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
            if (st_q == HS_HOLD && cnt_q != HOLD_LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign preq_o = (st_q == HS_REQ);
    assign busy_o = (st_q != HS_IDLE);

endmodule

// File: rtl/pch_state_reg.sv
module pch_state_reg #(
    parameter int                 STATE_W    = 4,
    parameter logic [STATE_W-1:0] INIT_STATE = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               commit_i,
    input  logic [STATE_W-1:0] target_i,
    output logic [STATE_W-1:0] pstate_o,
    output logic [STATE_W-1:0] cur_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pstate_o <= INIT_STATE;
            cur_o    <= INIT_STATE;
        end else begin
            if (load_i)   pstate_o <= target_i;
            if (commit_i) cur_o    <= pstate_o;
        end
    end

endmodule

// File: rtl/pch_err_mon.sv
module pch_err_mon (
    input  logic clk,
    input  logic rst,
    input  logic preq_i,
    input  logic paccept_i,
    input  logic pdeny_i,
    output logic err_o
);

    logic acc_q, dny_q, viol;

    always_comb begin
        viol = (paccept_i && pdeny_i)
            || (!preq_i && paccept_i && !acc_q)
            || (!preq_i && pdeny_i && !dny_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
            dny_q <= 1'b0;
            err_o <= 1'b0;
        end else begin
            acc_q <= paccept_i;
            dny_q <= pdeny_i;
            if (viol) err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pch_ctrl.sv
module pch_ctrl
    import pch_pkg::*;
#(
    parameter int                 STATE_W    = 4,
    parameter logic [STATE_W-1:0] INIT_STATE = '0,
    parameter int                 RST_HOLD   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [STATE_W-1:0] target_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               denied_o,
    output logic [STATE_W-1:0] cur_state_o,
    output logic               err_o,
    output logic               preq_o,
    output logic [STATE_W-1:0] pstate_o,
    input  logic               paccept_i,
    input  logic               pdeny_i
);

    hs_ctrl_t ctrl;

    pch_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .paccept_i (paccept_i),
        .pdeny_i   (pdeny_i),
        .preq_o    (preq_o),
        .busy_o    (busy_o),
        .ctrl_o    (ctrl)
    );

    pch_state_reg #(.STATE_W(STATE_W), .INIT_STATE(INIT_STATE)) u_state (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ctrl.load),
        .commit_i (ctrl.commit),
        .target_i (target_i),
        .pstate_o (pstate_o),
        .cur_o    (cur_state_o)
    );

    pch_err_mon u_err (
        .clk       (clk),
        .rst       (rst),
        .preq_i    (preq_o),
        .paccept_i (paccept_i),
        .pdeny_i   (pdeny_i),
        .err_o     (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            denied_o <= 1'b0;
        end else begin
            done_o   <= ctrl.finish;
            denied_o <= ctrl.finish && (ctrl.result == RES_DENY);
        end
    end

endmodule

// File: rtl/pch_ctrl_chk.sv
module pch_ctrl_chk #(
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               denied_o,
    input logic               err_o,
    input logic               preq_o,
    input logic [STATE_W-1:0] pstate_o,
    input logic               paccept_i,
    input logic               pdeny_i
);

    p_preq_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(preq_o) |-> $past(!paccept_i && !pdeny_i));

    p_preq_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(preq_o) |-> $past(paccept_i ^ pdeny_i));

    p_pstate_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(pstate_o) |-> $past(!preq_o && !paccept_i && !pdeny_i));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_denied_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        denied_o |-> done_o);

    p_busy_start_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(pstate_o));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

bind pch_ctrl pch_ctrl_chk #(.STATE_W(STATE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .denied_o  (denied_o),
    .err_o     (err_o),
    .preq_o    (preq_o),
    .pstate_o  (pstate_o),
    .paccept_i (paccept_i),
    .pdeny_i   (pdeny_i)
);

// File: tb/sim_pch_ctrl.sv
`timescale 1ns/1ps
module sim_pch_ctrl;

    localparam int         W    = 4;
    localparam logic [3:0] INIT = 4'hA;
    localparam int         HOLD = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] target_i = '0;
    logic         busy_o, done_o, denied_o, err_o, preq_o;
    logic [W-1:0] cur_state_o, pstate_o;
    logic         paccept_i = 1'b0;
    logic         pdeny_i = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pch_ctrl #(.STATE_W(W), .INIT_STATE(INIT), .RST_HOLD(HOLD)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
        .busy_o(busy_o), .done_o(done_o), .denied_o(denied_o),
        .cur_state_o(cur_state_o), .err_o(err_o), .preq_o(preq_o),
        .pstate_o(pstate_o), .paccept_i(paccept_i), .pdeny_i(pdeny_i)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; start_i = 1'b0; paccept_i = 1'b0; pdeny_i = 1'b0;
        step(); step();
        rst = 1'b0;
        repeat (HOLD + 1) step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        check("R1 preq", preq_o, 0);
        check("R1 pstate", pstate_o, INIT);
        check("R1 cur", cur_state_o, INIT);
        check("R1 busy", busy_o, 1);
        check("R1 done", done_o, 0);
        check("R1 denied", denied_o, 0);
        check("R1 err", err_o, 0);
    endtask

    task automatic t_hold();
        rst = 1'b0;
        start_i = 1'b1; target_i = 4'h3;
        step();
        check("R2 busy in hold", busy_o, 1);
        check("R2 pstate in hold", pstate_o, INIT);
        start_i = 1'b0;
        repeat (HOLD + 1) step();
        check("R2 idle after hold", busy_o, 0);
        check("R2 pstate kept", pstate_o, INIT);
        check("R2 no request", preq_o, 0);
    endtask

    task automatic t_handshake(input logic [W-1:0] tgt, input logic deny);
        logic [W-1:0] prev;
        prev = cur_state_o;
        start_i = 1'b1; target_i = tgt;
        step();
        start_i = 1'b0;
        check("R3 pstate loaded", pstate_o, tgt);
        check("R3 preq low in setup", preq_o, 0);
        check("R10 busy", busy_o, 1);
        step();
        check("R3 preq high", preq_o, 1);
        if (deny) pdeny_i = 1'b1; else paccept_i = 1'b1;
        step();
        check("R4 preq dropped", preq_o, 0);
        check("R7 cur state", cur_state_o, deny ? prev : tgt);
        step();
        check("R6 no done before drop", done_o, 0);
        paccept_i = 1'b0; pdeny_i = 1'b0;
        step();
        check("R6 done", done_o, 1);
        check("R6 denied flag", denied_o, deny);
        check("R10 busy low at done", busy_o, 0);
        check("R7 cur after done", cur_state_o, deny ? prev : tgt);
        step();
        check("R6 done one cycle", done_o, 0);
        check("R9 no error", err_o, 0);
    endtask

    task automatic t_busy_ignore();
        start_i = 1'b1; target_i = 4'h5;
        step();
        target_i = 4'hC;
        step();
        step();
        check("R8 pstate frozen while busy", pstate_o, 4'h5);
        start_i = 1'b0;
        paccept_i = 1'b1;
        step();
        paccept_i = 1'b0;
        step();
        check("R8 done", done_o, 1);
        step();
        check("R8 no new request", busy_o, 0);
        check("R8 pstate unchanged", pstate_o, 4'h5);
    endtask

    task automatic t_both_high();
        start_i = 1'b1; target_i = 4'h9;
        step();
        start_i = 1'b0;
        step();
        paccept_i = 1'b1; pdeny_i = 1'b1;
        step();
        check("R4 preq held on both", preq_o, 1);
        check("R9 err on both", err_o, 1);
        pdeny_i = 1'b0;
        step();
        check("R4 preq drops on single", preq_o, 0);
        paccept_i = 1'b0;
        step();
        check("R6 done after accept", done_o, 1);
        check("R9 err sticky", err_o, 1);
        do_reset();
        check("R9 err cleared by reset", err_o, 0);
    endtask

    task automatic t_rise_low();
        paccept_i = 1'b1;
        start_i = 1'b1; target_i = 4'h2;
        step();
        check("R9 err on stray accept", err_o, 1);
        check("R8 start ignored with accept high", busy_o, 0);
        check("R8 pstate unchanged", pstate_o, 4'h5);
        start_i = 1'b0; paccept_i = 1'b0;
        step();
        check("R9 err stays", err_o, 1);
        do_reset();
        pdeny_i = 1'b1;
        step();
        check("R9 err on stray deny", err_o, 1);
        pdeny_i = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_hold();
                t_handshake(4'h3, 1'b0);
                t_handshake(4'h7, 1'b1);
                t_handshake(4'hE, 1'b0);
                t_busy_ignore();
                t_rise_low();
                do_reset();
                t_both_high();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule